// File: doc/BRIEF.md
# Set-Associative Translation Cache

This block keeps recently used virtual-to-physical page mappings for an address translation unit so that most accesses avoid a table walk. Pages of 4 KiB, 64 KiB and 1 MiB share one array of 64 sets by 8 ways. The set is chosen from the 4 KiB page number bits of the virtual address. Each entry remembers its own page size, and the size sets how much of the tag takes part in the compare.

A client presents a virtual address on the lookup port and gets hit, multi-hit and the physical address one cycle later. A table walker writes its result through the fill port. The fill never checks for an existing copy, so the walker is expected to fill only after a miss. Maintenance software can empty the whole cache with a flush. It can also remove entries with an address-based invalidate that acts on a single set. A 1 MiB page can have copies in every set and a 64 KiB page in 16 neighbouring sets, so removing such a page takes one invalidate for every 4 KiB step of its range.

Top module: `xlt_cache`

## Requirements
- R1: A lookup request in one cycle gives `rsp_valid` high in the next cycle together with its result. `rsp_valid` is low in the cycle after a cycle with no request. On a miss, `rsp_hit`, `rsp_multi` and `rsp_pa` are all zero.
- R2: Size code 0 is 4 KiB, 1 is 64 KiB and 2 is 1 MiB; code 3 acts as 4 KiB. A valid entry matches when virtual bits [31:12], [31:16] or [31:20] are equal, depending on its size. The returned address takes its bits above the page offset from the stored frame and its offset bits from the looked-up address.
- R3: Virtual bits [17:12] select the set for lookups, fills and invalidates. A large-page entry therefore serves only lookups whose bits [17:12] equal those of the address it was filled with.
- R4: When more than one way matches, `rsp_hit` and `rsp_multi` are both high, and `rsp_pa` comes from the lowest-numbered matching way.
- R5: A flush clears every entry. A fill in the same cycle is dropped.
- R6: An invalidate command acts only when its bit 0 is 1, and it then clears every matching entry of the set given by its bits [17:12]. A command with bit 0 at 0 changes nothing. Copies of the same page in other sets survive.
- R7: An active invalidate and a fill in the same cycle: the invalidate is done and the fill is dropped.
- R8: A fill goes into the lowest-numbered invalid way of its set when there is one.
- R9: With `lru_mode` high and the set full, a fill replaces the way least recently filled or hit by a single-way lookup hit.
- R10: With `lru_mode` low and the set full, a fill replaces the way named by a per-set pointer. The pointer starts at 0 and advances by one on each such replacement.
- R11: After reset every entry is invalid and all response outputs are zero.
- R12: A lookup in the same cycle as a fill, flush or invalidate sees the contents from before that update. A lookup in the following cycle sees the new contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| lru_mode | input | 1 | 1: least-recently-used replacement, 0: round-robin |
| lookup_req | input | 1 | Lookup request |
| lookup_va | input | 32 | Virtual address to translate |
| rsp_valid | output | 1 | Lookup result valid |
| rsp_hit | output | 1 | At least one way matched |
| rsp_multi | output | 1 | More than one way matched |
| rsp_pa | output | 32 | Translated physical address |
| fill_req | input | 1 | Write a walk result |
| fill_va | input | 32 | Virtual address that was walked |
| fill_pa | input | 32 | Physical frame base of the page |
| fill_size | input | 2 | Page size code |
| flush_req | input | 1 | Invalidate all entries |
| inval_req | input | 1 | Address invalidate strobe |
| inval_cmd | input | 32 | Invalidate command: page address, bit 0 = act |

## Verification
Directed cases cover each page size with offsets at both ends of the page. This separates a correct size mask from one that uses the wrong number of tag bits. Other directed cases place large-page copies in two sets, so a single invalidate is shown to remove only one copy. Fills into full sets under each replacement mode show which way is evicted, because only the evicted page turns into a miss. Random traffic is confined to four sets and a few 1 MiB regions. This forces duplicate entries, multi-hits, same-cycle conflicts and mixed sizes in one set, and a reference model written from the requirements checks every response.

// File: rtl/xlt_pkg.sv
// Shared widths, entry layout and size-dependent masks for the translation cache.
// Assumes equal virtual and physical address widths and a 4 KiB base page.
package xlt_pkg;
    localparam int VA_W  = 32;
    localparam int PA_W  = 32;
    localparam int OFS_W = 12;
    localparam int VPN_W = VA_W - OFS_W;
    localparam int PPN_W = PA_W - OFS_W;

    typedef enum logic [1:0] {
        PG_4K   = 2'd0,
        PG_64K  = 2'd1,
        PG_1M   = 2'd2,
        PG_RSVD = 2'd3
    } pg_size_e;

    typedef struct packed {
        logic               valid;
        pg_size_e           size;
        logic [VPN_W-1:0]   vpn;
        logic [PPN_W-1:0]   ppn;
    } xlt_entry_t;

    // Page-number bits that take part in the tag compare for a size
    function automatic logic [VPN_W-1:0] vpn_mask(input pg_size_e sz);
        case (sz)
            PG_64K:  vpn_mask = ~VPN_W'(32'hF);
            PG_1M:   vpn_mask = ~VPN_W'(32'hFF);
            default: vpn_mask = '1;
        endcase
    endfunction

    // Page-offset bits of a physical address for a size
    function automatic logic [PA_W-1:0] offset_mask(input pg_size_e sz);
        offset_mask = ~{vpn_mask(sz), {OFS_W{1'b0}}};
    endfunction
endpackage

// File: rtl/xlt_way_match.sv
// Compares one set's ways against a virtual page number under each entry's own size mask.
// Assumes the caller has already selected the set.
module xlt_way_match
    import xlt_pkg::*;
#(
    parameter int WAYS = 8
) (
    input  xlt_entry_t [WAYS-1:0] set_ents,
    input  logic [VPN_W-1:0]      q_vpn,
    output logic [WAYS-1:0]       hits
);
    // One comparator per way
    for (genvar w = 0; w < WAYS; w++) begin : g_way
        assign hits[w] = set_ents[w].valid &&
            (((set_ents[w].vpn ^ q_vpn) & vpn_mask(set_ents[w].size)) == '0);
    end
endmodule

// File: rtl/xlt_victim_pick.sv
// Chooses the way a fill overwrites: lowest invalid way, else oldest age or the round-robin pointer.
// Assumes WAYS is a power of two and the ages form a permutation of 0..WAYS-1.
module xlt_victim_pick #(
    parameter int WAYS  = 8,
    parameter int WAY_W = $clog2(WAYS)
) (
    input  logic [WAYS-1:0]             valid_vec,
    input  logic [WAYS-1:0][WAY_W-1:0]  ages,
    input  logic [WAY_W-1:0]            rr_ptr,
    input  logic                        lru_mode,
    output logic [WAY_W-1:0]            victim,
    output logic                        take_rr
);
    logic               have_free;
    logic [WAY_W-1:0]   free_idx;
    logic [WAY_W-1:0]   oldest;

    // Find the lowest invalid way and the way with the highest age
    always_comb begin
        have_free = 1'b0;
        free_idx  = '0;
        oldest    = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (!valid_vec[w]) begin
                have_free = 1'b1;
                free_idx  = WAY_W'(w);
            end
        end
        for (int w = 0; w < WAYS; w++) begin
            if (ages[w] == WAY_W'(WAYS - 1)) begin
                oldest = WAY_W'(w);
            end
        end
    end

    // Final choice by policy
    always_comb begin
        if (have_free) begin
            victim = free_idx;
        end else if (lru_mode) begin
            victim = oldest;
        end else begin
            victim = rr_ptr;
        end
        take_rr = !have_free && !lru_mode;
    end
endmodule

// File: rtl/xlt_repl_state.sv
// Per-set replacement state: a recency age per way and a round-robin pointer.
// Assumes at most one touch per cycle; ages stay a permutation of 0..WAYS-1.
module xlt_repl_state #(
    parameter int SETS  = 64,
    parameter int WAYS  = 8,
    parameter int SET_W = $clog2(SETS),
    parameter int WAY_W = $clog2(WAYS)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        touch_en,
    input  logic [SET_W-1:0]            touch_set,
    input  logic [WAY_W-1:0]            touch_way,
    input  logic                        rr_adv,
    input  logic [SET_W-1:0]            rd_set,
    output logic [WAYS-1:0][WAY_W-1:0]  rd_ages,
    output logic [WAY_W-1:0]            rd_rr
);
    logic [WAYS-1:0][WAY_W-1:0] age_q [SETS];
    logic [WAY_W-1:0]           rr_q  [SETS];
    logic [WAY_W-1:0]           touched_age;

    assign touched_age = age_q[touch_set][touch_way];

    // Age update on touch: touched way becomes youngest, younger ways age by one
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) begin
                for (int w = 0; w < WAYS; w++) begin
                    age_q[s][w] <= WAY_W'(w);
                end
            end
        end else if (touch_en) begin
            for (int w = 0; w < WAYS; w++) begin
                if (WAY_W'(w) == touch_way) begin
                    age_q[touch_set][w] <= '0;
                end else if (age_q[touch_set][w] < touched_age) begin
                    age_q[touch_set][w] <= age_q[touch_set][w] + 1'b1;
                end
            end
        end
    end

    // Round-robin pointer advance after a pointer-chosen replacement
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) begin
                rr_q[s] <= '0;
            end
        end else if (rr_adv) begin
            rr_q[rd_set] <= rr_q[rd_set] + 1'b1;
        end
    end

    assign rd_ages = age_q[rd_set];
    assign rd_rr   = rr_q[rd_set];
endmodule

// File: rtl/xlt_cache.sv
// Translation cache top: SETS x WAYS entries of mixed page size, indexed by VA bits above 4 KiB.
// Lookup result is registered; flush beats invalidate beats fill; lookups see pre-update contents.
module xlt_cache
    import xlt_pkg::*;
#(
    parameter int SETS = 64,
    parameter int WAYS = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lru_mode,
    input  logic              lookup_req,
    input  logic [VA_W-1:0]   lookup_va,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic              rsp_multi,
    output logic [PA_W-1:0]   rsp_pa,
    input  logic              fill_req,
    input  logic [VA_W-1:0]   fill_va,
    input  logic [PA_W-1:0]   fill_pa,
    input  logic [1:0]        fill_size,
    input  logic              flush_req,
    input  logic              inval_req,
    input  logic [VA_W-1:0]   inval_cmd
);
    localparam int SET_W = $clog2(SETS);
    localparam int WAY_W = $clog2(WAYS);

    xlt_entry_t [WAYS-1:0] tbl_q [SETS];

    logic [SET_W-1:0]           lk_set, fl_set, iv_set;
    logic [WAYS-1:0]            lk_hits, iv_hits, fl_valid;
    logic                       lk_any, lk_single;
    logic [WAY_W-1:0]           lk_first;
    logic [PA_W-1:0]            lk_pa;
    logic                       inval_act, fill_acc;
    logic [WAY_W-1:0]           victim, rr_ptr;
    logic                       take_rr;
    logic [WAYS-1:0][WAY_W-1:0] fl_ages;
    logic                       touch_en;
    logic [SET_W-1:0]           touch_set;
    logic [WAY_W-1:0]           touch_way;

    assign lk_set    = lookup_va[OFS_W +: SET_W];
    assign fl_set    = fill_va[OFS_W +: SET_W];
    assign iv_set    = inval_cmd[OFS_W +: SET_W];
    assign inval_act = inval_req && inval_cmd[0];
    assign fill_acc  = fill_req && !flush_req && !inval_act;

    xlt_way_match #(.WAYS(WAYS)) u_lk_match (
        .set_ents (tbl_q[lk_set]),
        .q_vpn    (lookup_va[VA_W-1:OFS_W]),
        .hits     (lk_hits)
    );

    xlt_way_match #(.WAYS(WAYS)) u_iv_match (
        .set_ents (tbl_q[iv_set]),
        .q_vpn    (inval_cmd[VA_W-1:OFS_W]),
        .hits     (iv_hits)
    );

    // Lowest matching way, hit count class and translated address
    always_comb begin
        lk_first = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (lk_hits[w]) begin
                lk_first = WAY_W'(w);
            end
        end
        lk_any    = |lk_hits;
        lk_single = lk_any && ((lk_hits & (lk_hits - WAYS'(1))) == '0);
        lk_pa     = ({tbl_q[lk_set][lk_first].ppn, {OFS_W{1'b0}}}
                     & ~offset_mask(tbl_q[lk_set][lk_first].size))
                  | (PA_W'(lookup_va) & offset_mask(tbl_q[lk_set][lk_first].size));
    end

    // Valid bits of the fill set for victim choice
    always_comb begin
        for (int w = 0; w < WAYS; w++) begin
            fl_valid[w] = tbl_q[fl_set][w].valid;
        end
    end

    xlt_victim_pick #(.WAYS(WAYS), .WAY_W(WAY_W)) u_pick (
        .valid_vec (fl_valid),
        .ages      (fl_ages),
        .rr_ptr    (rr_ptr),
        .lru_mode  (lru_mode),
        .victim    (victim),
        .take_rr   (take_rr)
    );

    // Recency touch source: an accepted fill, else a single-way lookup hit
    always_comb begin
        if (fill_acc) begin
            touch_en  = 1'b1;
            touch_set = fl_set;
            touch_way = victim;
        end else begin
            touch_en  = lookup_req && lk_single;
            touch_set = lk_set;
            touch_way = lk_first;
        end
    end

    xlt_repl_state #(.SETS(SETS), .WAYS(WAYS), .SET_W(SET_W), .WAY_W(WAY_W)) u_repl (
        .clk       (clk),
        .rst_n     (rst_n),
        .touch_en  (touch_en),
        .touch_set (touch_set),
        .touch_way (touch_way),
        .rr_adv    (fill_acc && take_rr),
        .rd_set    (fl_set),
        .rd_ages   (fl_ages),
        .rd_rr     (rr_ptr)
    );

    // Entry array update: flush, else invalidate, else fill
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) begin
                tbl_q[s] <= '0;
            end
        end else if (flush_req) begin
            for (int s = 0; s < SETS; s++) begin
                for (int w = 0; w < WAYS; w++) begin
                    tbl_q[s][w].valid <= 1'b0;
                end
            end
        end else if (inval_act) begin
            for (int w = 0; w < WAYS; w++) begin
                if (iv_hits[w]) begin
                    tbl_q[iv_set][w].valid <= 1'b0;
                end
            end
        end else if (fill_acc) begin
            tbl_q[fl_set][victim] <= '{valid: 1'b1,
                                       size:  pg_size_e'(fill_size),
                                       vpn:   fill_va[VA_W-1:OFS_W],
                                       ppn:   fill_pa[PA_W-1:OFS_W]};
        end
    end

    // Registered lookup response
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_hit   <= 1'b0;
            rsp_multi <= 1'b0;
            rsp_pa    <= '0;
        end else begin
            rsp_valid <= lookup_req;
            rsp_hit   <= lookup_req && lk_any;
            rsp_multi <= lookup_req && lk_any && !lk_single;
            rsp_pa    <= (lookup_req && lk_any) ? lk_pa : '0;
        end
    end
endmodule

// File: rtl/xlt_cache_chk.sv
// Protocol checks on the translation cache ports, attached by bind.
// Assumes the synchronous active-low reset of the checked block.
module xlt_cache_chk
    import xlt_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              lookup_req,
    input logic              flush_req,
    input logic              rsp_valid,
    input logic              rsp_hit,
    input logic              rsp_multi,
    input logic [PA_W-1:0]   rsp_pa
);
    AST_RSP_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        lookup_req |=> rsp_valid); // R1

    AST_NO_RSP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !lookup_req |=> !rsp_valid); // R1

    AST_HIT_NEEDS_RSP: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_valid |-> (!rsp_hit && !rsp_multi)); // R1

    AST_MISS_PA_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_hit) |-> (rsp_pa == '0)); // R1

    AST_MULTI_IS_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_multi |-> rsp_hit); // R4

    AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        (flush_req ##1 lookup_req) |=> !rsp_hit); // R5
endmodule

bind xlt_cache xlt_cache_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .lookup_req (lookup_req),
    .flush_req  (flush_req),
    .rsp_valid  (rsp_valid),
    .rsp_hit    (rsp_hit),
    .rsp_multi  (rsp_multi),
    .rsp_pa     (rsp_pa)
);

// File: tb/xlt_cache_bench.sv
// Self-checking bench: directed corner cases plus seeded random traffic against a requirement model.
module xlt_cache_bench;
    localparam int NS = 64;
    localparam int NW = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lru_mode = 1'b1;
    logic        lookup_req = 1'b0;
    logic [31:0] lookup_va = '0;
    logic        rsp_valid, rsp_hit, rsp_multi;
    logic [31:0] rsp_pa;
    logic        fill_req = 1'b0;
    logic [31:0] fill_va = '0;
    logic [31:0] fill_pa = '0;
    logic [1:0]  fill_size = '0;
    logic        flush_req = 1'b0;
    logic        inval_req = 1'b0;
    logic [31:0] inval_cmd = '0;

    int nchk = 0;
    int nfail = 0;

    always #5 clk = ~clk;

    xlt_cache u_xlt_cache (
        .clk(clk), .rst_n(rst_n), .lru_mode(lru_mode),
        .lookup_req(lookup_req), .lookup_va(lookup_va),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_multi(rsp_multi), .rsp_pa(rsp_pa),
        .fill_req(fill_req), .fill_va(fill_va), .fill_pa(fill_pa), .fill_size(fill_size),
        .flush_req(flush_req), .inval_req(inval_req), .inval_cmd(inval_cmd)
    );

    // Reference model state
    bit          m_v   [NS][NW];
    logic [19:0] m_vpn [NS][NW];
    logic [19:0] m_ppn [NS][NW];
    logic [1:0]  m_sz  [NS][NW];
    int          m_age [NS][NW];
    int          m_rr  [NS];

    function automatic logic [31:0] omask(input logic [1:0] s);
        case (s)
            2'd1:    return 32'h0000_FFFF;
            2'd2:    return 32'h000F_FFFF;
            default: return 32'h0000_0FFF;
        endcase
    endfunction

    function automatic bit mhit(input int s, input int w, input logic [31:0] va);
        return m_v[s][w] && ((({m_vpn[s][w], 12'h000} ^ va) & ~omask(m_sz[s][w])) == 32'h0);
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic touch(input int s, input int w);
        int a;
        a = m_age[s][w];
        for (int v = 0; v < NW; v++) begin
            if (v == w) m_age[s][v] = 0;
            else if (m_age[s][v] < a) m_age[s][v]++;
        end
    endtask

    // One cycle of stimulus; model predicts and the response is checked after the edge
    task automatic step(input bit lk, input logic [31:0] lva,
                        input bit fl, input logic [31:0] fva, input logic [31:0] fpa,
                        input logic [1:0] fsz, input bit fsh,
                        input bit iv, input logic [31:0] icmd, input string tag);
        int ls, fs, is, nh, fw, vic;
        bit use_rr, iact, facc, e_hit, e_multi;
        logic [31:0] e_pa;
        @(negedge clk);
        lookup_req = lk; lookup_va = lva;
        fill_req = fl; fill_va = fva; fill_pa = fpa; fill_size = fsz;
        flush_req = fsh; inval_req = iv; inval_cmd = icmd;
        ls = int'(lva[17:12]); fs = int'(fva[17:12]); is = int'(icmd[17:12]);
        nh = 0; fw = -1;
        for (int w = 0; w < NW; w++) begin
            if (mhit(ls, w, lva)) begin
                nh++;
                if (fw < 0) fw = w;
            end
        end
        e_hit = nh > 0; e_multi = nh > 1;
        e_pa = e_hit ? (({m_ppn[ls][fw], 12'h000} & ~omask(m_sz[ls][fw])) | (lva & omask(m_sz[ls][fw])))
                     : 32'h0;
        vic = -1; use_rr = 1'b0;
        for (int w = 0; w < NW; w++) if (!m_v[fs][w] && vic < 0) vic = w;
        if (vic < 0) begin
            if (lru_mode) begin
                for (int w = 0; w < NW; w++) if (m_age[fs][w] == NW - 1) vic = w;
            end else begin
                vic = m_rr[fs]; use_rr = 1'b1;
            end
        end
        iact = iv && icmd[0];
        facc = fl && !fsh && !iact;
        if (fsh) begin
            for (int s = 0; s < NS; s++) for (int w = 0; w < NW; w++) m_v[s][w] = 1'b0;
        end else if (iact) begin
            for (int w = 0; w < NW; w++) if (mhit(is, w, icmd)) m_v[is][w] = 1'b0;
        end else if (facc) begin
            m_v[fs][vic] = 1'b1; m_vpn[fs][vic] = fva[31:12];
            m_ppn[fs][vic] = fpa[31:12]; m_sz[fs][vic] = fsz;
        end
        if (facc) touch(fs, vic);
        else if (lk && nh == 1) touch(ls, fw);
        if (facc && use_rr) m_rr[fs] = (m_rr[fs] + 1) % NW;
        @(posedge clk); #1;
        chk(rsp_valid == lk, {tag, " R1 valid"}, 32'(rsp_valid), 32'(lk));
        if (lk) begin
            chk(rsp_hit == e_hit, {tag, " hit"}, 32'(rsp_hit), 32'(e_hit));
            chk(rsp_multi == e_multi, {tag, " R4 multi"}, 32'(rsp_multi), 32'(e_multi));
            chk(rsp_pa == e_pa, {tag, " pa"}, rsp_pa, e_pa);
        end
    endtask

    task automatic look(input logic [31:0] va, input string tag);
        step(1'b1, va, 1'b0, 32'h0, 32'h0, 2'd0, 1'b0, 1'b0, 32'h0, tag);
    endtask

    task automatic fill(input logic [31:0] va, input logic [31:0] pa, input logic [1:0] sz, input string tag);
        step(1'b0, 32'h0, 1'b1, va, pa, sz, 1'b0, 1'b0, 32'h0, tag);
    endtask

    task automatic inval(input logic [31:0] cmd, input string tag);
        step(1'b0, 32'h0, 1'b0, 32'h0, 32'h0, 2'd0, 1'b0, 1'b1, cmd, tag);
    endtask

    task automatic flush(input string tag);
        step(1'b0, 32'h0, 1'b0, 32'h0, 32'h0, 2'd0, 1'b1, 1'b0, 32'h0, tag);
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        nchk++; nfail++;
        $display("FAIL watchdog expired, requirement R1 actual=hung expected=done");
        summary();
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        for (int s = 0; s < NS; s++) begin
            m_rr[s] = 0;
            for (int w = 0; w < NW; w++) begin
                m_v[s][w] = 1'b0; m_age[s][w] = w;
                m_vpn[s][w] = '0; m_ppn[s][w] = '0; m_sz[s][w] = '0;
            end
        end
        repeat (4) @(posedge clk);
        @(negedge clk);
        // R11: outputs quiet in reset
        chk(!rsp_valid && !rsp_hit && !rsp_multi && rsp_pa == 0, "R11 reset outputs", rsp_pa, 32'h0);
        rst_n = 1'b1;
        look(32'h0001_2345, "R11 empty after reset");

        // R12: same-cycle lookup misses, next cycle hits
        step(1'b1, 32'h0001_2345, 1'b1, 32'h0001_2345, 32'hABCD_E000, 2'd0, 1'b0, 1'b0, 32'h0, "R12 same cycle");
        chk(!rsp_hit, "R12 same-cycle miss", 32'(rsp_hit), 32'h0);
        look(32'h0001_2FFF, "R2 4K");
        chk(rsp_pa == 32'hABCD_EFFF, "R2 4K pa", rsp_pa, 32'hABCD_EFFF);
        look(32'h0001_3000, "R2 4K next page");

        // R2/R3: 64 KiB page
        fill(32'h0034_5000, 32'h1230_0000, 2'd1, "R2 fill 64K");
        look(32'h0034_5ABC, "R2 64K");
        chk(rsp_pa == 32'h1230_5ABC, "R2 64K pa", rsp_pa, 32'h1230_5ABC);
        look(32'h0034_6ABC, "R3 64K other set");
        chk(!rsp_hit, "R3 64K other set miss", 32'(rsp_hit), 32'h0);

        // R2/R3: 1 MiB page
        fill(32'h0560_0000, 32'h7700_0000, 2'd2, "R2 fill 1M");
        look(32'h0564_0123, "R3 1M same set");
        chk(rsp_pa == 32'h7704_0123, "R2 1M pa", rsp_pa, 32'h7704_0123);
        look(32'h056F_F000, "R3 1M other set");

        // R4: duplicate fill gives multi-hit, lowest way wins
        fill(32'h0009_9000, 32'h1111_1000, 2'd0, "R4 fill a");
        fill(32'h0009_9000, 32'h2222_2000, 2'd0, "R4 fill b");
        look(32'h0009_9010, "R4 multi");
        chk(rsp_multi && rsp_pa == 32'h1111_1010, "R4 lowest way", rsp_pa, 32'h1111_1010);

        // R6: bit 0 clear has no effect, bit 0 set removes all matches
        inval(32'h0009_9000, "R6 inert cmd");
        look(32'h0009_9010, "R6 still present");
        chk(rsp_hit, "R6 inert cmd kept entry", 32'(rsp_hit), 32'h1);
        inval(32'h0009_9001, "R6 active cmd");
        look(32'h0009_9010, "R6 removed");
        chk(!rsp_hit, "R6 both copies removed", 32'(rsp_hit), 32'h0);

        // R6: 1 MiB copies in two sets, one command per 4 KiB step
        fill(32'h0A00_0000, 32'h3300_0000, 2'd2, "R6 1M copy set0");
        fill(32'h0A00_5000, 32'h3300_0000, 2'd2, "R6 1M copy set5");
        inval(32'h0A00_0001, "R6 one step");
        look(32'h0A00_5000, "R6 other copy");
        chk(rsp_hit, "R6 other set survives", 32'(rsp_hit), 32'h1);
        look(32'h0A00_0000, "R6 stepped copy");
        for (int k = 0; k < 64; k++) inval(32'h0A00_0001 + (32'(k) << 12), "R6 sweep");
        look(32'h0A00_5000, "R6 swept");
        chk(!rsp_hit, "R6 sweep removes all", 32'(rsp_hit), 32'h0);

        // R7: invalidate beats fill
        step(1'b0, 32'h0, 1'b1, 32'h000B_B000, 32'h4444_4000, 2'd0, 1'b0, 1'b1, 32'h0000_1001, "R7 conflict");
        look(32'h000B_B000, "R7 fill dropped");
        chk(!rsp_hit, "R7 fill dropped", 32'(rsp_hit), 32'h0);

        // R5: flush clears and drops a same-cycle fill
        step(1'b0, 32'h0, 1'b1, 32'h000C_C000, 32'h5555_5000, 2'd0, 1'b1, 1'b0, 32'h0, "R5 flush+fill");
        look(32'h0001_2345, "R5 flushed");
        chk(!rsp_hit, "R5 flush cleared", 32'(rsp_hit), 32'h0);
        look(32'h000C_C000, "R5 fill dropped");

        // R9: least-recently-used eviction
        lru_mode = 1'b1;
        for (int k = 1; k <= 8; k++) fill((32'(k) << 18) | 32'h7000, 32'(k) << 20, 2'd0, "R8 fill set7");
        look((32'd1 << 18) | 32'h7000, "R9 touch first");
        fill((32'd9 << 18) | 32'h7000, 32'h0900_0000, 2'd0, "R9 fill full set");
        look((32'd1 << 18) | 32'h7000, "R9 touched kept");
        chk(rsp_hit, "R9 touched page kept", 32'(rsp_hit), 32'h1);
        look((32'd2 << 18) | 32'h7000, "R9 oldest evicted");
        chk(!rsp_hit, "R9 oldest evicted", 32'(rsp_hit), 32'h0);

        // R8: freed way is reused before any eviction
        inval((32'd3 << 18) | 32'h7001, "R8 free one");
        fill((32'd10 << 18) | 32'h7000, 32'h0A00_0000, 2'd0, "R8 refill");
        for (int k = 4; k <= 8; k++) begin
            look((32'(k) << 18) | 32'h7000, "R8 others kept");
            chk(rsp_hit, "R8 others kept", 32'(rsp_hit), 32'h1);
        end

        // R10: round-robin eviction
        flush("R10 clean");
        lru_mode = 1'b0;
        for (int k = 1; k <= 8; k++) fill((32'(k) << 18) | 32'h9000, 32'(k) << 20, 2'd0, "R10 fill set9");
        look((32'd1 << 18) | 32'h9000, "R10 touch");
        fill((32'd9 << 18) | 32'h9000, 32'h0900_0000, 2'd0, "R10 first evict");
        look((32'd1 << 18) | 32'h9000, "R10 way0 evicted");
        chk(!rsp_hit, "R10 pointer way0 evicted", 32'(rsp_hit), 32'h0);
        fill((32'd10 << 18) | 32'h9000, 32'h0A00_0000, 2'd0, "R10 second evict");
        look((32'd2 << 18) | 32'h9000, "R10 way1 evicted");
        chk(!rsp_hit, "R10 pointer advanced", 32'(rsp_hit), 32'h0);

        // Random traffic over four sets and a few large regions (R1, R2, R3)
        for (int i = 0; i < 4000; i++) begin
            logic [31:0] va, fva, icmd;
            if (i == 2000) lru_mode = 1'b1;
            va   = $urandom & 32'h0030_3FFF;
            fva  = $urandom & 32'h0030_3FFF;
            icmd = ($urandom & 32'h0030_3000) | 32'($urandom % 2);
            step($urandom % 2 == 0, va, $urandom % 3 == 0, fva, $urandom & 32'hFFFF_F000,
                 2'($urandom % 4), $urandom % 97 == 0, $urandom % 7 == 0, icmd, "R2 R3 random");
        end

        step(1'b0, 32'h0, 1'b0, 32'h0, 32'h0, 2'd0, 1'b0, 1'b0, 32'h0, "R1 idle");
        summary();
        $finish;
    end
endmodule